// File: doc/BRIEF.md
# Programmable Pad and Max-Pool Tile Unit

This block assembles a 4x4 output tile of feature-map values out of a stream of 4x4 input tiles, one instruction per input tile. Each instruction names, for each of four subset-maximum units, which of the sixteen incoming values take part in that unit's maximum. It also gives every output position a select code that either loads one of those four results or keeps what the position already holds. Because the pooling window lives entirely in the instruction stream, any window size, stride or padding pattern can be built up over several input tiles: 2x2 pooling with stride 2 is one instruction per input tile, each filling four output positions, and padding is a one-value mask, or an empty mask that yields zero.

Values are 9 bits wide in sign-and-magnitude form. The maximum is taken with signed meaning, and the two encodings of zero compare equal. An instruction can clear the whole output tile before its own update, and can ask for the updated tile to be emitted. Input and output each use a valid/ready handshake, and with the consumer ready the unit takes a new tile and instruction on every clock.

Top module: `poolpad_tile_unit`

## Requirements
- R1: Each subset-maximum unit u (0..3) takes its mask from in_masks[16u+15:16u], where bit j includes input value j (in_tile[9j+8:9j]). It returns the largest included value, comparing with signed meaning: bit 8 is the sign (1 = negative) and bits 7:0 the magnitude.
- R2: A subset-maximum unit whose mask is all zero returns the value +0 (9'h000).
- R3: +0 (9'h000) and -0 (9'h100) compare equal, and a maximum whose magnitude is zero is always returned as +0, so a zero result never carries the sign bit.
- R4: Output position i reads its 3-bit select code from in_sel[3i+2:3i]. Code 0 keeps the position's value, codes 1 to 4 load subset-maximum unit 0 to 3, and codes 5 to 7 keep the value just as code 0 does.
- R5: When in_clear is set on an accepted instruction, every output position is taken to zero before that instruction's selects are applied.
- R6: When in_emit is set on an accepted instruction, out_valid is high in the following cycle, and out_tile then holds all sixteen positions after that instruction's update, in the same bit layout as in_tile.
- R7: An accepted instruction without in_emit updates the output positions but does not raise out_valid, and an emitted tile that the consumer takes is not presented again.
- R8: While out_valid is high and out_ready is low, in_ready is low, no instruction is accepted, and out_tile and out_valid hold steady.
- R9: With out_ready held high, in_ready stays high and one instruction is accepted on every clock, each emitting instruction producing its own output tile in the next cycle.
- R10: After reset out_valid is low, in_ready is high, and all sixteen output positions hold +0.
- R11: A cycle with in_valid low changes no output position, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Tile and instruction are present |
| in_ready | output | 1 | Unit can accept a tile and instruction this cycle |
| in_tile | input | 144 | Sixteen 9-bit sign-magnitude input values, value j at bits 9j+8:9j |
| in_masks | input | 64 | Four 16-bit subset masks, unit u at bits 16u+15:16u |
| in_sel | input | 48 | Sixteen 3-bit output select codes, position i at bits 3i+2:3i |
| in_clear | input | 1 | Zero all output positions before this update |
| in_emit | input | 1 | Present the updated output tile |
| out_valid | output | 1 | Output tile is presented |
| out_ready | input | 1 | Consumer takes the output tile |
| out_tile | output | 144 | Sixteen 9-bit output values, same layout as in_tile |

## Verification
The bench goes after the signed comparison between negative values and between the two zeros. A design that compared raw bit patterns would rank every negative value above every positive one, and one that skipped the zero fix-up would emit -0. An empty mask is loaded over a non-zero position, so a unit that returned a stale or arbitrary value instead of zero shows at once. The reserved select codes must behave as holds: a design that decoded only the low two bits would load a unit's maximum instead. Back-pressure is held for several cycles with a second instruction waiting, which catches a design that overwrote the presented tile or accepted work while stalled. Idle cycles with clear and emit asserted but valid low must leave the tile untouched.

// File: rtl/poolpad_pkg.sv
package poolpad_pkg;

  // Default geometry of the tile unit.
  localparam int unsigned PP_MAG_W  = 8;   // magnitude bits; one sign bit sits above
  localparam int unsigned PP_TILE_N = 16;  // values per tile (4x4), power of two
  localparam int unsigned PP_MAX_N  = 4;   // subset-maximum units
  localparam int unsigned PP_SEL_W  = 3;   // per-output select code width

  // Output select codes; every code above SEL_UNIT3 behaves as SEL_KEEP.
  typedef enum logic [PP_SEL_W-1:0] {
    SEL_KEEP  = 3'd0,
    SEL_UNIT0 = 3'd1,
    SEL_UNIT1 = 3'd2,
    SEL_UNIT2 = 3'd3,
    SEL_UNIT3 = 3'd4
  } out_sel_e;

endpackage

// File: rtl/poolpad_subset_max.sv
// Maximum of a masked subset of one tile, as a balanced comparison tree.
module poolpad_subset_max #(
  parameter int unsigned MAG_W  = 8,
  parameter int unsigned TILE_N = 16
) (
  input  logic [TILE_N*(MAG_W+1)-1:0] tile_i,
  input  logic [TILE_N-1:0]           mask_i,
  output logic [MAG_W:0]              max_o
);
  localparam int unsigned VAL_W = MAG_W + 1;
  localparam int unsigned KEY_W = MAG_W + 1;
  localparam int unsigned NODES = 2*TILE_N - 1;

  // Signed ordering key of a sign-magnitude value; both zeros map to 0.
  function automatic logic signed [KEY_W-1:0] key_of(input logic [VAL_W-1:0] v);
    logic signed [KEY_W-1:0] m;
    m = $signed({1'b0, v[MAG_W-1:0]});
    return v[MAG_W] ? -m : m;
  endfunction

  // Heap-ordered tree: node k (1-based) lives at index k-1, leaves at TILE_N..2*TILE_N-1.
  logic             nvld [NODES];
  logic [VAL_W-1:0] nval [NODES];

  genvar j, k;
  generate
    for (j = 0; j < TILE_N; j++) begin : g_leaf
      assign nvld[TILE_N+j-1] = mask_i[j];
      assign nval[TILE_N+j-1] = tile_i[j*VAL_W +: VAL_W];
    end
    for (k = 1; k < TILE_N; k++) begin : g_node
      logic take_l;
      assign take_l = nvld[2*k-1] &&
                      (!nvld[2*k] || (key_of(nval[2*k-1]) >= key_of(nval[2*k])));
      assign nvld[k-1] = nvld[2*k-1] | nvld[2*k];
      assign nval[k-1] = take_l ? nval[2*k-1] : nval[2*k];
    end
  endgenerate

  // Empty subset or a zero result both leave as +0.
  assign max_o = (nvld[0] && (nval[0][MAG_W-1:0] != '0)) ? nval[0] : '0;

endmodule

// File: rtl/poolpad_out_select.sv
// Next value of one output position: clear, then keep or load a unit maximum.
module poolpad_out_select
  import poolpad_pkg::*;
#(
  parameter int unsigned MAG_W = 8,
  parameter int unsigned MAX_N = 4,
  parameter int unsigned SEL_W = 3
) (
  input  logic [MAG_W:0]               cur_i,
  input  logic                         clear_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [MAX_N*(MAG_W+1)-1:0]   max_i,
  output logic [MAG_W:0]               nxt_o
);
  localparam int unsigned VAL_W = MAG_W + 1;

  always_comb begin
    nxt_o = clear_i ? '0 : cur_i;
    if (sel_i != SEL_W'(SEL_KEEP)) begin
      for (int u = 0; u < MAX_N; u++) begin
        if (sel_i == SEL_W'(u + 1)) nxt_o = max_i[u*VAL_W +: VAL_W];
      end
    end
  end

endmodule

// File: rtl/poolpad_out_stage.sv
// Single output register with valid/ready; frees itself when drained.
module poolpad_out_stage #(
  parameter int unsigned DATA_W = 144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              free_o
);
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q;

  assign free_o = !vld_q || out_ready_i;

  always_comb begin
    vld_d = vld_q;
    if (load_i)           vld_d = 1'b1;
    else if (out_ready_i) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_i) dat_q <= data_i;
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;

  // R8: a stalled tile stays presented and unchanged
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready_i) |=> (vld_q && $stable(dat_q)));

  // R6: an emitting instruction presents a tile next cycle
  p_emit_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> vld_q);

  // R7: a taken tile is not presented again without a new emit
  p_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && out_ready_i && !load_i) |=> !vld_q);

endmodule

// File: rtl/poolpad_tile_unit.sv
// Instruction-driven pad / max-pool tile unit.
module poolpad_tile_unit
  import poolpad_pkg::*;
#(
  parameter int unsigned MAG_W  = PP_MAG_W,
  parameter int unsigned TILE_N = PP_TILE_N,
  parameter int unsigned MAX_N  = PP_MAX_N,
  parameter int unsigned SEL_W  = PP_SEL_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [TILE_N*(MAG_W+1)-1:0]  in_tile,
  input  logic [MAX_N*TILE_N-1:0]      in_masks,
  input  logic [TILE_N*SEL_W-1:0]      in_sel,
  input  logic                         in_clear,
  input  logic                         in_emit,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [TILE_N*(MAG_W+1)-1:0]  out_tile
);
  localparam int unsigned VAL_W  = MAG_W + 1;
  localparam int unsigned TILE_W = TILE_N * VAL_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic                     accept;
  logic                     stage_free;
  logic [TILE_W-1:0]        acc_q, acc_d, acc_nxt;
  logic [MAX_N*VAL_W-1:0]   unit_max;

  assign in_ready = stage_free;
  assign accept   = in_valid && in_ready;

  genvar u, i;
  generate
    for (u = 0; u < MAX_N; u++) begin : g_unit
      poolpad_subset_max #(.MAG_W(MAG_W), .TILE_N(TILE_N)) u_max (
        .tile_i (in_tile),
        .mask_i (in_masks[u*TILE_N +: TILE_N]),
        .max_o  (unit_max[u*VAL_W +: VAL_W])
      );

      // R3: a zero maximum never carries the sign bit
      p_zero_canon_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
        (unit_max[u*VAL_W +: MAG_W] == '0) |-> !unit_max[u*VAL_W + MAG_W]);
    end

    for (i = 0; i < TILE_N; i++) begin : g_pos
      poolpad_out_select #(.MAG_W(MAG_W), .MAX_N(MAX_N), .SEL_W(SEL_W)) u_sel (
        .cur_i   (acc_q[i*VAL_W +: VAL_W]),
        .clear_i (in_clear),
        .sel_i   (in_sel[i*SEL_W +: SEL_W]),
        .max_i   (unit_max),
        .nxt_o   (acc_nxt[i*VAL_W +: VAL_W])
      );

      // R4: a keep code without clear leaves the position as it was
      p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
        (accept && !in_clear && (in_sel[i*SEL_W +: SEL_W] == '0))
        |=> (acc_q[i*VAL_W +: VAL_W] == $past(acc_q[i*VAL_W +: VAL_W])));
    end
  endgenerate

  always_comb begin
    acc_d = acc_q;
    if (accept) acc_d = acc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) acc_q <= '0;
    else            acc_q <= acc_d;
  end

  poolpad_out_stage #(.DATA_W(TILE_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .load_i      (accept && in_emit),
    .data_i      (acc_nxt),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .out_data_o  (out_tile),
    .free_o      (stage_free)
  );

  // R11: no accepted instruction, no change to the positions
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    !accept |=> $stable(acc_q));

  // R5: clear with every position keeping gives an all-zero tile
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (accept && in_clear && (in_sel == '0)) |=> (acc_q == '0));

endmodule

// File: tb/poolpad_tile_unit_test.sv
module poolpad_tile_unit_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, in_clear, in_emit;
  logic [143:0] in_tile;
  logic [63:0]  in_masks;
  logic [47:0]  in_sel;
  logic         out_valid, out_ready;
  logic [143:0] out_tile;

  always #10 clk = ~clk;  // 50 MHz

  poolpad_tile_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tile(in_tile), .in_masks(in_masks), .in_sel(in_sel),
    .in_clear(in_clear), .in_emit(in_emit), .out_valid(out_valid),
    .out_ready(out_ready), .out_tile(out_tile)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [8:0] mdl [16];

  typedef struct packed {
    logic [7:0]  seed;
    logic [63:0] masks;
    logic [47:0] sel;
    logic        clr;
    logic        emit;
  } vec_t;

  // Masks: quadrants for 2x2/stride 2, single-value / empty for padding, mixed.
  localparam vec_t TBL [8] = '{
    '{8'd3,  64'hCC00_3300_00CC_0033, 48'h0000_0000_08D1, 1'b1, 1'b0},
    '{8'd7,  64'hCC00_3300_00CC_0033, 48'h0000_008D_1000, 1'b0, 1'b0},
    '{8'd12, 64'hCC00_3300_00CC_0033, 48'h0008_D100_0000, 1'b0, 1'b0},
    '{8'd20, 64'hCC00_3300_00CC_0033, 48'h8D10_0000_0000, 1'b0, 1'b1},
    '{8'd33, 64'h8000_FFFF_0000_0020, 48'h8D18_D18D_18D1, 1'b1, 1'b1},
    '{8'd41, 64'hFFFF_0F0F_F0F0_0001, 48'h2492_4924_9249, 1'b0, 1'b1},
    '{8'd58, 64'h0001_0002_0004_0008, 48'hFFFF_FFFF_FFFF, 1'b0, 1'b1},
    '{8'd99, 64'h1111_2222_4444_8888, 48'h8D18_D18D_18D1, 1'b0, 1'b1}
  };

  function automatic logic [143:0] gen_tile(input int seed);
    logic [143:0] t;
    for (int j = 0; j < 16; j++) begin
      t[j*9 +: 8] = 8'((seed*37 + j*53 + 11) % 256);
      t[j*9 + 8]  = ((seed + j) % 3) == 0;
    end
    return t;
  endfunction

  function automatic logic [143:0] put(input logic [143:0] t, input int idx, input logic [8:0] v);
    logic [143:0] r;
    r = t;
    r[idx*9 +: 9] = v;
    return r;
  endfunction

  // Reference maximum from the requirements (R1, R2, R3).
  function automatic logic [8:0] ref_max(input logic [143:0] t, input logic [15:0] m);
    int  best;
    bit  found;
    int  v;
    found = 0;
    best  = 0;
    for (int j = 0; j < 16; j++) begin
      v = t[j*9+8] ? -int'(t[j*9 +: 8]) : int'(t[j*9 +: 8]);
      if (m[j] && (!found || v > best)) begin
        best  = v;
        found = 1;
      end
    end
    if (!found || best == 0) return 9'h000;
    if (best < 0) return {1'b1, 8'(-best)};
    return {1'b0, 8'(best)};
  endfunction

  task automatic mdl_update(input logic [143:0] t, input logic [63:0] m,
                            input logic [47:0] s, input logic c);
    logic [8:0] mx [4];
    int code;
    for (int u = 0; u < 4; u++) mx[u] = ref_max(t, m[u*16 +: 16]);
    for (int i = 0; i < 16; i++) begin
      code = int'(s[i*3 +: 3]);
      if (c) mdl[i] = 9'h000;
      if (code >= 1 && code <= 4) mdl[i] = mx[code-1];
    end
  endtask

  function automatic logic [143:0] mdl_flat();
    logic [143:0] f;
    for (int i = 0; i < 16; i++) f[i*9 +: 9] = mdl[i];
    return f;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [143:0] act, input logic [143:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_tile(input string tag);
    chk(out_valid === 1'b1 && out_tile === mdl_flat(), tag, out_tile, mdl_flat());
  endtask

  // Drive at a falling edge; returns at the next falling edge, outputs updated.
  task automatic send(input logic [143:0] t, input logic [63:0] m,
                      input logic [47:0] s, input logic c, input logic e);
    in_tile = t; in_masks = m; in_sel = s; in_clear = c; in_emit = e;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    mdl_update(t, m, s, c);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [143:0] t, hold_a;
    rst_n = 1'b0; in_valid = 1'b0; in_clear = 1'b0; in_emit = 1'b0;
    in_tile = '0; in_masks = '0; in_sel = '0; out_ready = 1'b1;
    for (int i = 0; i < 16; i++) mdl[i] = 9'h000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk(out_valid === 1'b0, "R10 out_valid after reset", 144'(out_valid), 144'(0));
    chk(in_ready === 1'b1, "R10 in_ready after reset", 144'(in_ready), 144'(1));
    send(gen_tile(5), 64'h0, 48'h0, 1'b0, 1'b1);
    chk_tile("R10 positions zero after reset");

    // Table walk: R1 R4 R6 R7 over pooling, padding and mixed patterns
    for (int n = 0; n < 8; n++) begin
      send(gen_tile(int'(TBL[n].seed)), TBL[n].masks, TBL[n].sel, TBL[n].clr, TBL[n].emit);
      chk(out_valid === TBL[n].emit, "R6 R7 table out_valid", 144'(out_valid), 144'(TBL[n].emit));
      if (TBL[n].emit) chk_tile("R1 R4 R6 table tile");
    end
    @(negedge clk);

    // R1 R2 R3: signed compare, empty mask, zero canonical form
    t = '0;
    t = put(t, 0, 9'h1C8);  // -200
    t = put(t, 1, 9'h045);  // +69
    t = put(t, 2, 9'h103);  // -3
    t = put(t, 3, 9'h1C8);  // -200
    t = put(t, 4, 9'h100);  // -0
    t = put(t, 6, 9'h105);  // -5
    send(t, 64'h0000_0000_0000_0040, 48'h2492_4924_9249, 1'b0, 1'b0);
    send(t, 64'h0000_0050_000A_0005, 48'h0000_0000_08D1, 1'b0, 1'b1);
    chk(out_tile[0*9 +: 9] === 9'h103, "R1 max of two negatives", 144'(out_tile[0*9 +: 9]), 144'(9'h103));
    chk(out_tile[1*9 +: 9] === 9'h045, "R1 positive above negative", 144'(out_tile[1*9 +: 9]), 144'(9'h045));
    chk(out_tile[2*9 +: 9] === 9'h000, "R3 -0 versus -5 gives +0", 144'(out_tile[2*9 +: 9]), 144'(9'h000));
    chk(out_tile[3*9 +: 9] === 9'h000, "R2 empty mask gives zero", 144'(out_tile[3*9 +: 9]), 144'(9'h000));
    chk(out_tile[4*9 +: 9] === 9'h105, "R4 keep code holds", 144'(out_tile[4*9 +: 9]), 144'(9'h105));
    chk_tile("R1 R2 R3 whole tile");

    // R4: reserved codes 5 and 6 keep every position
    send(gen_tile(77), 64'hFFFF_FFFF_FFFF_FFFF, 48'hB6DB_6DB6_DB6D, 1'b0, 1'b1);
    chk_tile("R4 reserved code 5 holds");
    send(gen_tile(78), 64'hFFFF_FFFF_FFFF_FFFF, 48'hDB6D_B6DB_6DB6, 1'b0, 1'b1);
    chk_tile("R4 reserved code 6 holds");

    // R5: clear before update
    t = put(144'h0, 9, 9'h07F);
    send(t, 64'h0, 48'h0, 1'b1, 1'b1);
    chk(out_tile === 144'h0, "R5 clear with keep", out_tile, 144'h0);
    send(t, 64'h0000_0000_0000_0200, 48'h2492_4924_9249, 1'b0, 1'b0);
    send(t, 64'h0000_0000_0000_0200, 48'h0000_0000_8000, 1'b1, 1'b1);
    chk(out_tile === put(144'h0, 5, 9'h07F), "R5 clear then load one position",
        out_tile, put(144'h0, 5, 9'h07F));
    @(negedge clk);

    // R11: idle cycles with clear/emit/selects set but valid low
    in_tile = gen_tile(200); in_masks = '1; in_sel = 48'h8D18_D18D_18D1;
    in_clear = 1'b1; in_emit = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11 nothing emitted while idle", 144'(out_valid), 144'(0));
    send(gen_tile(1), 64'h0, 48'h0, 1'b0, 1'b1);
    chk_tile("R11 positions unchanged by idle cycles");
    @(negedge clk);

    // R7: update without emit, then emit
    send(gen_tile(9), 64'h00F0_0F00_F000_000F, 48'h8D18_D18D_18D1, 1'b0, 1'b0);
    chk(out_valid === 1'b0, "R7 no emit no valid", 144'(out_valid), 144'(0));
    send(gen_tile(10), 64'h0, 48'h0, 1'b0, 1'b1);
    chk_tile("R7 earlier update kept and emitted");
    @(negedge clk);

    // R8: back-pressure
    out_ready = 1'b0;
    send(gen_tile(30), 64'h0F0F_F0F0_00FF_FF00, 48'h0000_0000_08D1, 1'b0, 1'b1);
    hold_a = mdl_flat();
    chk(in_ready === 1'b0, "R8 in_ready low while stalled", 144'(in_ready), 144'(0));
    in_tile = gen_tile(31); in_masks = 64'hFFFF_FFFF_FFFF_FFFF;
    in_sel = 48'h2492_4924_9249; in_clear = 1'b0; in_emit = 1'b1; in_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b1 && out_tile === hold_a, "R8 tile held during stall", out_tile, hold_a);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    mdl_update(gen_tile(31), 64'hFFFF_FFFF_FFFF_FFFF, 48'h2492_4924_9249, 1'b0);
    chk_tile("R8 waiting instruction taken after drain");
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 drained tile not repeated", 144'(out_valid), 144'(0));

    // R9: back-to-back instructions, one per clock
    for (int n = 0; n < 3; n++) begin
      chk(in_ready === 1'b1, "R9 in_ready stays high", 144'(in_ready), 144'(1));
      send(gen_tile(120 + n), 64'hA5A5_5A5A_3C3C_C3C3, (n == 1) ? 48'h8D18_D18D_18D1 : 48'h2492_4924_9249,
           n == 2, 1'b1);
      chk_tile("R9 consecutive output tile");
    end

    finish_run();
  end

endmodule